// File: doc/BRIEF.md
# UART Register and Receive-Buffer Front End

This block is the software-facing side of a simple UART. Over a zero-wait-state APB slave port it offers a data register, a read-only status word and a fully writable control word. A deserializer delivers received bytes on a valid/ready stream. Those bytes are held in a small first-in, first-out buffer, but only while reception is enabled. Software removes the oldest byte by reading the data register.

A write to the data register sends its low byte out on a one-cycle transmit strobe, provided transmission is enabled. Storing a received byte and sending a byte each raise a registered one-clock interrupt pulse when the matching control bit allows it.

Only address bits 7:0 are decoded. The data register answers at byte offset 0x00 and also at 0x03, so a single-byte access reaches it. Baud generation, bit framing, parity and the scaler are not part of this block.

Top module: `uart_reg_front`

## Requirements
- R1: Only paddr_i[7:0] is decoded. Data sits at 0x00 and 0x03, status at 0x04 and control at 0x08. The scaler at 0x0C and every other offset read 0 and ignore writes.
- R2: The control word is 32 bits wide, reads back the value last written, and a write changes it from the cycle after the access phase.
- R3: The status word is read-only. Bit 0 is data ready (buffer not empty), bits 1 and 2 (transmit shifter empty, transmit queue empty) read 1, and all other bits read 0. Writes to it have no effect.
- R4: A byte that completes the rx handshake (rx_valid_i and rx_ready_o) is stored only when control bit 0 (receive enable) is 1. Storing it sets data ready from the next cycle.
- R5: A read of the data register returns the oldest stored byte in prdata_o[7:0], with zeros above it, and removes that byte. Bytes leave in arrival order.
- R6: A read of the data register while the buffer is empty returns 0, and data ready stays 0.
- R7: rx_ready_o is 0 while RX_DEPTH bytes are held. No stored byte is overwritten.
- R8: A data-register write with control bit 1 (transmit enable) set drives tx_valid_o high for exactly the one cycle after the access phase, with tx_data_o equal to pwdata_i[7:0]. With bit 1 clear, nothing is sent.
- R9: irq_o pulses for one cycle after a store when control bit 2 is 1, and after a send when control bit 3 is 1. A store and a send in the same cycle give a single pulse. With the bits clear, no pulse is produced.
- R10: pready_o is always 1 and pslverr_o is always 0.
- R11: After reset the control word is 0, the buffer is empty and the status word reads 0x6.
- R12: When a byte is stored in the same cycle as a data-register read, the read returns the older byte, the new byte is kept, and data ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when 1 |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| pslverr_o | output | 1 | APB error, always 0 |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Buffer can accept a byte |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| tx_data_o | output | 8 | Byte to transmit |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Two pairs of events can fall into the same cycle.

The first pair is a byte arriving and software popping the buffer. The bench provokes it by raising rx_valid_i during the access phase of a data-register read. It then judges the result by the byte returned, by data ready remaining 1, and by the later read returning the newer byte.

The second pair is a receive store and a transmit write meeting in one cycle with both interrupt enables set. The bench provokes it the same way and requires exactly one irq_o pulse alongside the transmit strobe.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] OFF_DATA   = 8'h00;
  localparam logic [7:0] OFF_DATA_B = 8'h03;
  localparam logic [7:0] OFF_STAT   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;

  localparam int unsigned CTL_RX_EN  = 0;
  localparam int unsigned CTL_TX_EN  = 1;
  localparam int unsigned CTL_RX_IRQ = 2;
  localparam int unsigned CTL_TX_IRQ = 3;

  localparam int unsigned ST_RX_RDY   = 0;
  localparam int unsigned ST_SH_EMPTY = 1;
  localparam int unsigned ST_TQ_EMPTY = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      // Draining the last byte rewinds both pointers.
      if (do_pop && !do_push && cnt_q == CW'(1)) begin
        wr_q <= '0;
        rd_q <= '0;
      end else begin
        if (do_push) wr_q <= wr_q + AW'(1);
        if (do_pop)  rd_q <= rd_q + AW'(1);
      end
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end
endmodule

// File: rtl/uart_irq_pulse.sv
module uart_irq_pulse #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(evt_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [REG_W-1:0]  pwdata_i,
  output logic [REG_W-1:0]  prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [7:0]        off;
  logic              acc_rd, acc_wr;
  logic [REG_W-1:0]  ctrl_q;
  logic [REG_W-1:0]  status_w;
  logic              rx_push, rx_pop, tx_fire;
  logic              buf_empty, buf_full;
  logic [BYTE_W-1:0] buf_head;
  logic              tx_valid_q;
  logic [BYTE_W-1:0] tx_data_q;
  logic              unused_addr;

  assign off         = paddr_i[7:0];
  assign unused_addr = ^paddr_i[ADDR_W-1:8];
  assign acc_rd      = psel_i & penable_i & ~pwrite_i;
  assign acc_wr      = psel_i & penable_i & pwrite_i;

  always_comb begin
    unique case (off)
      OFF_DATA, OFF_DATA_B: sel = SEL_DATA;
      OFF_STAT:             sel = SEL_STAT;
      OFF_CTRL:             sel = SEL_CTRL;
      default:              sel = SEL_NONE;
    endcase
  end

  assign rx_ready_o = ~buf_full;
  assign rx_push    = rx_valid_i & rx_ready_o & ctrl_q[CTL_RX_EN];
  assign rx_pop     = acc_rd & (sel == SEL_DATA);
  assign tx_fire    = acc_wr & (sel == SEL_DATA) & ctrl_q[CTL_TX_EN];

  uart_rx_buf #(
    .DEPTH (RX_DEPTH),
    .DW    (BYTE_W)
  ) u_rx_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_push),
    .push_data_i (rx_data_i),
    .pop_i       (rx_pop),
    .head_o      (buf_head),
    .empty_o     (buf_empty),
    .full_o      (buf_full)
  );

  always_comb begin
    status_w              = '0;
    status_w[ST_RX_RDY]   = ~buf_empty;
    status_w[ST_SH_EMPTY] = 1'b1;
    status_w[ST_TQ_EMPTY] = 1'b1;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: prdata_o = buf_empty ? '0 : REG_W'(buf_head);
      SEL_STAT: prdata_o = status_w;
      SEL_CTRL: prdata_o = ctrl_q;
      default:  prdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (acc_wr && sel == SEL_CTRL) ctrl_q <= pwdata_i;
      tx_valid_q <= tx_fire;
      if (tx_fire) tx_data_q <= pwdata_i[BYTE_W-1:0];
    end
  end

  uart_irq_pulse #(
    .N_SRC (2)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  ({tx_fire, rx_push}),
    .en_i   ({ctrl_q[CTL_TX_IRQ], ctrl_q[CTL_RX_IRQ]}),
    .irq_o  (irq_o)
  );

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
  assign pready_o   = 1'b1;
  assign pslverr_o  = 1'b0;
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [31:0]       pwdata_i,
  input logic [31:0]       prdata_o,
  input logic              pready_o,
  input logic              pslverr_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic              irq_o,
  input logic              rx_push,
  input logic              rx_pop,
  input logic [31:0]       ctrl_q,
  input logic              buf_empty
);
  logic data_off;
  assign data_off = (paddr_i[7:0] == 8'h00) || (paddr_i[7:0] == 8'h03);

  a_r10_apb_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o);

  a_r8_tx_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(psel_i && penable_i && pwrite_i && ctrl_q[1]));

  a_r9_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past((rx_valid_i && rx_ready_o && ctrl_q[2]) ||
                    (psel_i && penable_i && pwrite_i && ctrl_q[3])));

  a_r4_ready_after_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |=> !buf_empty);

  a_r6_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && !pwrite_i && data_off && buf_empty) |-> prdata_o == 32'h0);

  a_r7_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ready_o && !rx_pop) |=> !rx_ready_o);

  a_r2_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pwrite_i && paddr_i[7:0] == 8'h08) |=> ctrl_q == $past(pwdata_i));
endmodule

bind uart_reg_front uart_reg_front_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/uart_reg_front_tb_top.sv
module uart_reg_front_tb_top;
  localparam time CLK_P = 4ns;
  localparam int unsigned DEPTH = 16;

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // R1 R2 R3: register-map walk
  localparam vec_t VEC [12] = '{
    '{1'b1, 4'd2, 32'h0000_0008, 32'h0000_1FF0, 32'h0},
    '{1'b0, 4'd2, 32'h0000_0008, 32'h0,         32'h0000_1FF0},
    '{1'b1, 4'd3, 32'h0000_0004, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'd3, 32'h0000_0004, 32'h0,         32'h0000_0006},
    '{1'b1, 4'd1, 32'h0000_000C, 32'h0000_1234, 32'h0},
    '{1'b0, 4'd1, 32'h0000_000C, 32'h0,         32'h0},
    '{1'b0, 4'd1, 32'h0000_0010, 32'h0,         32'h0},
    '{1'b0, 4'd1, 32'h0000_0014, 32'h0,         32'h0},
    '{1'b0, 4'd1, 32'h0000_0108, 32'h0,         32'h0000_1FF0},
    '{1'b1, 4'd2, 32'h0000_0F08, 32'h8000_0000, 32'h0},
    '{1'b0, 4'd2, 32'h0000_0008, 32'h0,         32'h8000_0000},
    '{1'b0, 4'd3, 32'h0000_0204, 32'h0,         32'h0000_0006}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int n_chk = 0;
  int n_bad = 0;
  logic       tx_seen, irq_seen;
  logic [7:0] tx_byte;

  always #(CLK_P/2) clk = ~clk;

  uart_reg_front #(.ADDR_W(32), .RX_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                     input logic rxv, input logic [7:0] rxb, output logic [31:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge clk);
    penable = 1'b1; rx_valid = rxv; rx_data = rxb;
    #1 rd = prdata;
    chk("R10 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rx_valid = 1'b0;
    tx_seen = tx_valid; tx_byte = tx_data; irq_seen = irq;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    irq_seen = irq;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    apb(1'b0, 32'h08, 0, 1'b0, 8'h0, rd); chk("R11 ctrl after reset", rd, 32'h0);
    apb(1'b0, 32'h04, 0, 1'b0, 8'h0, rd); chk("R11 status after reset", rd, 32'h6);
    chk("R11 rx_ready after reset", {31'b0, rx_ready}, 32'h1);

    for (int i = 0; i < 12; i++) begin
      apb(VEC[i].wr, VEC[i].addr, VEC[i].wd, 1'b0, 8'h0, rd);
      if (!VEC[i].wr) chk($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
    end

    // R4: receive disabled drops the byte
    apb(1'b1, 32'h08, 32'h0, 1'b0, 8'h0, rd);
    push(8'h99);
    apb(1'b0, 32'h04, 0, 1'b0, 8'h0, rd); chk("R4 no store when disabled", rd, 32'h6);
    apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd); chk("R4 R6 empty data read", rd, 32'h0);

    // R4 R5 R9: store with rx interrupt, pop in order, offset 3
    apb(1'b1, 32'h08, 32'h5, 1'b0, 8'h0, rd);
    push(8'hA5); chk("R9 rx irq pulse", {31'b0, irq_seen}, 32'h1);
    @(negedge clk); chk("R9 irq one cycle", {31'b0, irq}, 32'h0);
    push(8'h3C);
    apb(1'b0, 32'h04, 0, 1'b0, 8'h0, rd); chk("R4 data ready set", rd, 32'h7);
    apb(1'b0, 32'h03, 0, 1'b0, 8'h0, rd); chk("R5 pop at offset 3", rd, 32'hA5);
    apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd); chk("R5 second byte", rd, 32'h3C);
    apb(1'b0, 32'h04, 0, 1'b0, 8'h0, rd); chk("R5 data ready cleared", rd, 32'h6);
    apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd); chk("R6 empty read returns 0", rd, 32'h0);
    apb(1'b0, 32'h04, 0, 1'b0, 8'h0, rd); chk("R6 data ready stays 0", rd, 32'h6);

    // R12: store and pop in the same cycle
    apb(1'b1, 32'h08, 32'h1, 1'b0, 8'h0, rd);
    push(8'h11);
    apb(1'b0, 32'h00, 0, 1'b1, 8'h22, rd); chk("R12 pop returns older", rd, 32'h11);
    apb(1'b0, 32'h04, 0, 1'b0, 8'h0, rd); chk("R12 data ready kept", rd, 32'h7);
    apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd); chk("R12 newer byte kept", rd, 32'h22);

    // R7: fill to depth
    for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i));
    chk("R7 rx_ready low when full", {31'b0, rx_ready}, 32'h0);
    push(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd);
      chk($sformatf("R7 R5 full drain %0d", i), rd, 32'h40 + 32'(i));
    end
    apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd); chk("R7 no overflow byte", rd, 32'h0);
    chk("R7 rx_ready back", {31'b0, rx_ready}, 32'h1);

    // R8: transmit disabled, then enabled
    apb(1'b1, 32'h08, 32'h0, 1'b0, 8'h0, rd);
    apb(1'b1, 32'h00, 32'h1234_5678, 1'b0, 8'h0, rd);
    chk("R8 no tx when disabled", {31'b0, tx_seen}, 32'h0);
    apb(1'b1, 32'h08, 32'h2, 1'b0, 8'h0, rd);
    apb(1'b1, 32'h03, 32'hAAAA_AA5A, 1'b0, 8'h0, rd);
    chk("R8 tx strobe", {31'b0, tx_seen}, 32'h1);
    chk("R8 tx byte", {24'b0, tx_byte}, 32'h5A);
    chk("R9 no irq when tx irq off", {31'b0, irq_seen}, 32'h0);
    @(negedge clk); chk("R8 strobe one cycle", {31'b0, tx_valid}, 32'h0);

    // R9: merged rx and tx events
    apb(1'b1, 32'h08, 32'hF, 1'b0, 8'h0, rd);
    apb(1'b1, 32'h00, 32'h0000_00C3, 1'b1, 8'h77, rd);
    chk("R9 merged irq", {31'b0, irq_seen}, 32'h1);
    chk("R8 tx with merge", {24'b0, tx_byte}, 32'hC3);
    @(negedge clk); chk("R9 merged single pulse", {31'b0, irq}, 32'h0);
    apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd); chk("R4 merged store", rd, 32'h77);

    // R11: reset mid-run
    push(8'h55);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    apb(1'b0, 32'h08, 0, 1'b0, 8'h0, rd); chk("R11 ctrl cleared", rd, 32'h0);
    apb(1'b0, 32'h04, 0, 1'b0, 8'h0, rd); chk("R11 status preset", rd, 32'h6);
    apb(1'b0, 32'h00, 0, 1'b0, 8'h0, rd); chk("R11 buffer flushed", rd, 32'h0);

    summary();
  end
endmodule